// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block is a calendar clock that occupies the eight highest byte addresses of a byte-wide memory space. It counts seconds, minutes, hours, day of week, date, month and year in packed BCD, and it advances once for each pulse on a one-second tick input. Carries run through the fields in order. Month lengths are correct, and February takes its leap day when the year value is a multiple of four. Software reaches the registers through a synchronous bus made of a chip enable, a write enable, an output enable, an address, write data and registered read data with a drive-enable flag.

The control byte at the lowest address of the window holds two bits. A read-hold bit freezes the visible registers so that a multi-byte read is coherent, while the counters keep running underneath. A write-hold bit lets software stage a full new time, and that time is loaded into the counters when the bit is cleared. The seconds byte contains a bit that stops the oscillator. The day byte contains a bit that enables a divided square-wave test output. Every bit that no clock field uses is plain read/write storage. A power-fail input blocks every bus access and pulls an active-low status output low, and timekeeping continues during a power fail.

Top module: `rtc_regbank`

## Requirements
- R1: The window is decoded when every address bit above bit 2 is one. Bits 2..0 select the register: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. An access outside the window has no effect and drives no data.
- R2: After reset the registers read: control 00, seconds 00, minutes 00, hours 00, day 01, date 01, month 01, year 00. All spare, stop and test bits are zero.
- R3: Each tick advances the BCD seconds. Seconds 59 and minutes 59 wrap to 00 and carry. Hours wrap 23 to 00 and advance both the day of week and the date. The day of week wraps 07 to 01. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R4: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other months except February. In February it wraps after 29 when the year is a multiple of four (00 included) and after 28 otherwise.
- R5: While seconds bit 7 (the stop bit) is one, ticks do not advance the time. The stop bit reads back as written.
- R6: While control bit 6 (read hold) is one, the time registers show a frozen snapshot and the counters keep advancing. From the second cycle after the bit is cleared, reads show the live time.
- R7: While control bit 7 (write hold) is one, writes to the time registers are staged and read back as written, and ticks do not change what is read. The write that clears the bit loads the staged values into the counters, and counting continues from them.
- R8: When write hold is zero, a write to a time register loads the counter field directly. The new value is visible on the next read.
- R9: These bits are plain storage that ticks leave unchanged: month bits 7..5, date bits 7..6, hour bits 7..6, minute bit 7, day bits 7, 5, 4 and 3, and control bits 5..0.
- R10: A read is an accepted cycle with chip enable high and write enable low. Its data appears on the read-data port one cycle later. Read-data enable is high only in the cycle after chip enable and output enable were both high with write enable low, and read data is zero when no read was accepted.
- R11: While the power-fail input is high, reads and writes have no effect and read-data enable stays low. One cycle later the power-fail output is low, and time keeps advancing.
- R12: While day bit 6 (frequency test) is one and the stop bit is zero, the test output toggles after every FT_HALF ticks, starting low. Otherwise it is held low, one cycle after the condition ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_ce | input | 1 | Chip enable, active high |
| bus_we | input | 1 | Write enable, active high |
| bus_oe | input | 1 | Output enable, active high |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rdata_en | output | 1 | Read data is driven |
| pwr_fail | input | 1 | Power-fail indication, blocks access |
| pwr_fail_n | output | 1 | Registered active-low power-fail status |
| ftest_out | output | 1 | Frequency test square wave |

## Verification
Random legal start times are loaded through write hold. The bench biases them toward month ends and 23:59, then runs a random number of ticks, so that the carry paths get exercised from many starting states rather than only from reset. Directed cases set the last day of a leap February, of a non-leap February, of the year 00 February and of a 30-day month, plus 99-12-31 23:59:59. These cases separate the leap rule and the month-length table from a plain 31-day wrap. Separate sequences compare the reads taken under read hold, under write hold, with the stop bit set and during power fail against a bench model that keeps advancing. This shows whether the hidden counters and the visible registers each behave as required.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

  localparam int REG_CNT = 8;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_t;

  localparam cal_t CAL_RST = '{yr: 8'h00, mon: 8'h01, date: 8'h01, day: 8'h01,
                               hr: 8'h00, min: 8'h00, sec: 8'h00};

  // Bits of each register owned by the time counters.
  function automatic logic [7:0] fld_mask(input logic [2:0] k);
    case (k)
      3'd1, 3'd2: fld_mask = 8'h7F;
      3'd3, 3'd5: fld_mask = 8'h3F;
      3'd4:       fld_mask = 8'h07;
      3'd6:       fld_mask = 8'h1F;
      3'd7:       fld_mask = 8'hFF;
      default:    fld_mask = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] cal_get(input cal_t t, input logic [2:0] k);
    case (k)
      3'd1:    cal_get = t.sec;
      3'd2:    cal_get = t.min;
      3'd3:    cal_get = t.hr;
      3'd4:    cal_get = t.day;
      3'd5:    cal_get = t.date;
      3'd6:    cal_get = t.mon;
      3'd7:    cal_get = t.yr;
      default: cal_get = 8'h00;
    endcase
  endfunction

  function automatic cal_t cal_put(input cal_t t, input logic [2:0] k,
                                   input logic [7:0] v);
    cal_t r;
    r = t;
    case (k)
      3'd1:    r.sec  = v;
      3'd2:    r.min  = v;
      3'd3:    r.hr   = v;
      3'd4:    r.day  = v;
      3'd5:    r.date = v;
      3'd6:    r.mon  = v;
      3'd7:    r.yr   = v;
      default: r = t;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_next = {v[7:4] + 4'd1, 4'd0};
    else                bcd_next = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // {carry, next}: wraps to bottom once the value reaches top.
  function automatic logic [8:0] bcd_roll(input logic [7:0] v, input logic [7:0] top,
                                          input logic [7:0] bottom);
    if (v >= top) bcd_roll = {1'b1, bottom};
    else          bcd_roll = {1'b0, bcd_next(v)};
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] ybin;
    ybin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
    case (mon)
      8'h02:                      month_last = (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_last = 8'h30;
      default:                    month_last = 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_time_core.sv
`timescale 1ns/1ps
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       load_all,
  input  cal_t       load_val,
  input  logic       fld_we,
  input  logic [2:0] fld_sel,
  input  logic [7:0] fld_val,
  output cal_t       cur_q,
  output cal_t       nxt
);

  cal_t adv;

  always_comb begin
    logic       c;
    logic [8:0] r;
    adv = cur_q;
    c   = step;
    r = bcd_roll(cur_q.sec, 8'h59, 8'h00);
    if (c) adv.sec = r[7:0];
    c = c & r[8];
    r = bcd_roll(cur_q.min, 8'h59, 8'h00);
    if (c) adv.min = r[7:0];
    c = c & r[8];
    r = bcd_roll(cur_q.hr, 8'h23, 8'h00);
    if (c) adv.hr = r[7:0];
    c = c & r[8];
    r = bcd_roll(cur_q.day, 8'h07, 8'h01);
    if (c) adv.day = r[7:0];
    r = bcd_roll(cur_q.date, month_last(cur_q.mon, cur_q.yr), 8'h01);
    if (c) adv.date = r[7:0];
    c = c & r[8];
    r = bcd_roll(cur_q.mon, 8'h12, 8'h01);
    if (c) adv.mon = r[7:0];
    c = c & r[8];
    r = bcd_roll(cur_q.yr, 8'h99, 8'h00);
    if (c) adv.yr = r[7:0];
  end

  always_comb begin
    if (load_all)    nxt = load_val;
    else if (fld_we) nxt = cal_put(adv, fld_sel, fld_val);
    else             nxt = adv;
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= CAL_RST;
    else     cur_q <= nxt;
  end

endmodule

// File: rtl/rtc_ftest_div.sv
`timescale 1ns/1ps
module rtc_ftest_div #(
  parameter int FT_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  output logic wave
);

  localparam int CW = (FT_HALF > 1) ? $clog2(FT_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(FT_HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      wave  <= 1'b0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        wave  <= ~wave;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rtc_regbank.sv
`timescale 1ns/1ps
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int FT_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              bus_ce,
  input  logic              bus_we,
  input  logic              bus_oe,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rdata_en,
  input  logic              pwr_fail,
  output logic              pwr_fail_n,
  output logic              ftest_out
);

  localparam int OFF_W = $clog2(REG_CNT);

  logic             win_hit;
  logic [OFF_W-1:0] off;
  logic             wr_acc, rd_acc;
  logic [7:0]       spare_q [REG_CNT];
  logic             wr_bit, rd_bit, osc_stop, ft_en, hold;
  logic             wr_release, fld_load, snap_wr;
  logic [7:0]       fld_in;
  cal_t             live_q, live_nxt, snap_q;

  assign win_hit = &bus_addr[ADDR_W-1:OFF_W];
  assign off     = bus_addr[OFF_W-1:0];
  assign wr_acc  = bus_ce & ~pwr_fail & win_hit & bus_we;
  assign rd_acc  = bus_ce & ~pwr_fail & win_hit & ~bus_we;
  assign fld_in  = bus_wdata & fld_mask(off);

  // Non-counter bits of every register: plain storage.
  for (genvar k = 0; k < REG_CNT; k++) begin : g_spare
    always_ff @(posedge clk) begin
      if (rst)
        spare_q[k] <= 8'h00;
      else if (wr_acc && off == OFF_W'(k))
        spare_q[k] <= bus_wdata & ~fld_mask(3'(k));
    end
  end

  assign wr_bit   = spare_q[0][7];
  assign rd_bit   = spare_q[0][6];
  assign osc_stop = spare_q[1][7];
  assign ft_en    = spare_q[4][6];
  assign hold     = wr_bit | rd_bit;

  assign wr_release = wr_acc && off == '0 && wr_bit && !bus_wdata[7];
  assign fld_load   = wr_acc && off != '0 && !wr_bit;
  assign snap_wr    = wr_acc && off != '0 && wr_bit;

  rtc_time_core core_i (
    .clk      (clk),
    .rst      (rst),
    .step     (tick_1hz & ~osc_stop),
    .load_all (wr_release),
    .load_val (snap_q),
    .fld_we   (fld_load),
    .fld_sel  (off),
    .fld_val  (fld_in),
    .cur_q    (live_q),
    .nxt      (live_nxt)
  );

  // Visible copy: tracks the counters unless a hold bit is set.
  always_ff @(posedge clk) begin
    if (rst)          snap_q <= CAL_RST;
    else if (!hold)   snap_q <= live_nxt;
    else if (snap_wr) snap_q <= cal_put(snap_q, off, fld_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata    <= 8'h00;
      bus_rdata_en <= 1'b0;
      pwr_fail_n   <= 1'b1;
    end else begin
      bus_rdata    <= rd_acc ? (cal_get(snap_q, off) | spare_q[off]) : 8'h00;
      bus_rdata_en <= rd_acc & bus_oe;
      pwr_fail_n   <= ~pwr_fail;
    end
  end

  rtc_ftest_div #(.FT_HALF(FT_HALF)) ftest_i (
    .clk  (clk),
    .rst  (rst),
    .en   (ft_en & ~osc_stop),
    .tick (tick_1hz),
    .wave (ftest_out)
  );

endmodule

// File: rtl/rtc_regbank_chk.sv
`timescale 1ns/1ps
module rtc_regbank_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_ce,
  input logic        bus_oe,
  input logic        pwr_fail,
  input logic        bus_rdata_en,
  input logic        pwr_fail_n,
  input logic        ftest_out,
  input logic        osc_stop,
  input logic        ft_en,
  input logic        rd_bit,
  input logic        wr_bit,
  input logic        fld_load,
  input logic        wr_release,
  input logic [55:0] live_flat,
  input logic [55:0] snap_flat
);

  assert_pf_block_R11: assert property (@(posedge clk) disable iff (rst)
    pwr_fail |=> (!pwr_fail_n && !bus_rdata_en));

  assert_drive_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_ce && bus_oe) |=> !bus_rdata_en);

  assert_stop_freezes_R5: assert property (@(posedge clk) disable iff (rst)
    (osc_stop && !fld_load && !wr_release) |=> $stable(live_flat));

  assert_read_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_bit && !wr_bit) |=> $stable(snap_flat));

  assert_write_load_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_bit) |-> (live_flat == snap_flat));

  assert_ftest_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !(ft_en && !osc_stop) |=> !ftest_out);

endmodule

bind rtc_regbank rtc_regbank_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .bus_ce       (bus_ce),
  .bus_oe       (bus_oe),
  .pwr_fail     (pwr_fail),
  .bus_rdata_en (bus_rdata_en),
  .pwr_fail_n   (pwr_fail_n),
  .ftest_out    (ftest_out),
  .osc_stop     (osc_stop),
  .ft_en        (ft_en),
  .rd_bit       (rd_bit),
  .wr_bit       (wr_bit),
  .fld_load     (fld_load),
  .wr_release   (wr_release),
  .live_flat    (live_q),
  .snap_flat    (snap_q)
);

// File: tb/rtc_regbank_tb.sv
`timescale 1ns/1ps
module rtc_regbank_tb_top;

  localparam int AW = 11;
  localparam int HALF = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_1hz = 1'b0;
  logic          bus_ce = 1'b0, bus_we = 1'b0, bus_oe = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = 8'h00;
  logic [7:0]    bus_rdata;
  logic          bus_rdata_en;
  logic          pwr_fail = 1'b0;
  logic          pwr_fail_n;
  logic          ftest_out;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  int m_s, m_mi, m_h, m_d, m_dt, m_mo, m_y;
  bit m_stop = 0;

  logic [7:0] rd_d;
  logic       rd_e;

  always #2.5 clk = ~clk;

  rtc_regbank #(.ADDR_W(AW), .FT_HALF(HALF)) dut_i (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_ce(bus_ce), .bus_we(bus_we),
    .bus_oe(bus_oe), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdata_en(bus_rdata_en), .pwr_fail(pwr_fail), .pwr_fail_n(pwr_fail_n),
    .ftest_out(ftest_out)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mlen(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_fld(input int k);
    case (k)
      1: return bcd(m_s);
      2: return bcd(m_mi);
      3: return bcd(m_h);
      4: return bcd(m_d);
      5: return bcd(m_dt);
      6: return bcd(m_mo);
      default: return bcd(m_y);
    endcase
  endfunction

  function automatic logic [7:0] msk(input int k);
    case (k)
      1, 2: return 8'h7F;
      3, 5: return 8'h3F;
      4: return 8'h07;
      6: return 8'h1F;
      7: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_tick();
    if (m_stop) return;
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_mi++;
      if (m_mi == 60) begin
        m_mi = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0;
          m_d = (m_d == 7) ? 1 : m_d + 1;
          m_dt++;
          if (m_dt > mlen(m_mo, m_y)) begin
            m_dt = 1; m_mo++;
            if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wr(input int k, input logic [7:0] d);
    bus_ce = 1; bus_we = 1; bus_oe = 0;
    bus_addr = {{(AW-3){1'b1}}, 3'(k)}; bus_wdata = d;
    @(negedge clk);
    bus_ce = 0; bus_we = 0;
  endtask

  task automatic rd_addr(input logic [AW-1:0] a, input bit oe);
    bus_ce = 1; bus_we = 0; bus_oe = oe; bus_addr = a;
    @(negedge clk);
    rd_d = bus_rdata; rd_e = bus_rdata_en;
    bus_ce = 0; bus_oe = 0;
  endtask

  task automatic rd(input int k);
    rd_addr({{(AW-3){1'b1}}, 3'(k)}, 1'b1);
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1hz = 1;
      @(negedge clk);
      tick_1hz = 0;
      model_tick();
    end
  endtask

  task automatic check_time(input string req);
    for (int k = 1; k < 8; k++) begin
      rd(k);
      check(rd_e && ((rd_d & msk(k)) == exp_fld(k)), req, rd_d & msk(k), exp_fld(k));
    end
  endtask

  task automatic set_time(input int y, input int mo, input int dt, input int d,
                          input int h, input int mi, input int s);
    wr(0, 8'h80);
    wr(7, bcd(y)); wr(6, bcd(mo)); wr(5, bcd(dt)); wr(4, bcd(d));
    wr(3, bcd(h)); wr(2, bcd(mi)); wr(1, bcd(s));
    wr(0, 8'h00);
    m_y = y; m_mo = mo; m_dt = dt; m_d = d; m_h = h; m_mi = mi; m_s = s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int sv_s, sv_mi, sv_h, sv_d, sv_dt, sv_mo, sv_y;
    logic [7:0] keep;
    void'($urandom(32'd20240611));
    m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_dt = 1; m_mo = 1; m_y = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R2 reset state
    rd(0); check(rd_d == 8'h00, "R2", rd_d, 8'h00);
    check_time("R2");
    check(pwr_fail_n == 1'b1 && ftest_out == 1'b0, "R2", {pwr_fail_n, ftest_out}, 2);

    // R3 full rollover
    set_time(99, 12, 31, 7, 23, 59, 59);
    do_tick(1);
    check_time("R3");
    check(m_y == 0 && m_d == 1 && m_mo == 1, "R3", m_y, 0);

    // R4 month ends
    set_time(4, 2, 28, 3, 23, 59, 59); do_tick(1); check_time("R4");
    check(m_dt == 29, "R4", m_dt, 29);
    set_time(4, 2, 29, 3, 23, 59, 59); do_tick(1); check_time("R4");
    set_time(3, 2, 28, 3, 23, 59, 59); do_tick(1); check_time("R4");
    set_time(0, 2, 28, 3, 23, 59, 59); do_tick(1); check_time("R4");
    set_time(21, 4, 30, 5, 23, 59, 59); do_tick(1); check_time("R4");

    // R1 window decode: outside addresses drive nothing
    rd_addr(11'h000, 1'b1);
    check(!rd_e && rd_d == 8'h00, "R1", {rd_e, rd_d}, 0);
    bus_ce = 1; bus_we = 1; bus_addr = 11'h001; bus_wdata = 8'h80;
    @(negedge clk); bus_ce = 0; bus_we = 0;
    do_tick(2);
    check_time("R1");

    // R10 output enable low: no drive
    rd_addr({{(AW-3){1'b1}}, 3'd1}, 1'b0);
    check(!rd_e, "R10", rd_e, 0);

    // R8 direct field write
    wr(2, bcd(42)); m_mi = 42;
    rd(2); check((rd_d & 8'h7F) == bcd(42), "R8", rd_d, bcd(42));

    // R5 stop bit
    wr(1, 8'h80 | bcd(m_s)); m_stop = 1;
    do_tick(5);
    rd(1); check(rd_d == (8'h80 | bcd(m_s)), "R5", rd_d, 8'h80 | bcd(m_s));
    check_time("R5");
    wr(1, bcd(m_s)); m_stop = 0;
    do_tick(3); check_time("R5");

    // R6 read hold
    wr(0, 8'h40);
    sv_s = m_s; sv_mi = m_mi;
    do_tick(3);
    rd(1); check((rd_d & 8'h7F) == bcd(sv_s), "R6", rd_d, bcd(sv_s));
    rd(2); check((rd_d & 8'h7F) == bcd(sv_mi), "R6", rd_d, bcd(sv_mi));
    wr(0, 8'h00); @(negedge clk);
    check_time("R6");

    // R7 write hold
    wr(0, 8'h80);
    sv_s = m_s; sv_mi = m_mi; sv_h = 5; sv_d = m_d; sv_dt = m_dt; sv_mo = m_mo; sv_y = m_y;
    wr(3, bcd(5));
    do_tick(4);
    rd(3); check((rd_d & 8'h3F) == bcd(5), "R7", rd_d, bcd(5));
    rd(1); check((rd_d & 8'h7F) == bcd(sv_s), "R7", rd_d, bcd(sv_s));
    wr(0, 8'h00);
    m_s = sv_s; m_mi = sv_mi; m_h = sv_h; m_d = sv_d; m_dt = sv_dt; m_mo = sv_mo; m_y = sv_y;
    check_time("R7");
    do_tick(2); check_time("R7");

    // R9 spare storage
    wr(6, 8'hE0 | bcd(m_mo)); keep = 8'hE0 | bcd(m_mo);
    wr(0, 8'h3F);
    wr(4, 8'hB8 | bcd(m_d));
    wr(2, 8'h80 | bcd(m_mi));
    do_tick(1);
    rd(0); check(rd_d == 8'h3F, "R9", rd_d, 8'h3F);
    rd(6); check(rd_d == keep, "R9", rd_d, keep);
    rd(4); check((rd_d & 8'hF8) == 8'hB8, "R9", rd_d & 8'hF8, 8'hB8);
    rd(2); check(rd_d[7] == 1'b1, "R9", rd_d, 8'h80);
    check_time("R9");
    wr(0, 8'h00); wr(6, bcd(m_mo)); wr(4, bcd(m_d)); wr(2, bcd(m_mi));

    // R11 power fail
    pwr_fail = 1;
    @(negedge clk);
    check(pwr_fail_n == 1'b0, "R11", pwr_fail_n, 0);
    wr(1, 8'h80);
    wr(0, 8'h40);
    rd(1); check(!rd_e && rd_d == 8'h00, "R11", {rd_e, rd_d}, 0);
    do_tick(3);
    pwr_fail = 0;
    @(negedge clk);
    check(pwr_fail_n == 1'b1, "R11", pwr_fail_n, 1);
    check_time("R11");
    rd(0); check(rd_d == 8'h00, "R11", rd_d, 0);

    // R12 frequency test
    wr(4, 8'h40 | bcd(m_d));
    check(ftest_out == 1'b0, "R12", ftest_out, 0);
    for (int i = 1; i <= 6; i++) begin
      do_tick(1);
      check(ftest_out == 1'((i / HALF) % 2), "R12", ftest_out, (i / HALF) % 2);
    end
    wr(1, 8'h80 | bcd(m_s)); m_stop = 1;
    @(negedge clk);
    check(ftest_out == 1'b0, "R12", ftest_out, 0);
    do_tick(2);
    check(ftest_out == 1'b0, "R12", ftest_out, 0);
    wr(1, bcd(m_s)); m_stop = 0;
    wr(4, bcd(m_d));

    // Random start times with carry bias (R3, R4)
    for (int it = 0; it < 16; it++) begin
      int y, mo, dt, d, h, mi, s, n;
      y = $urandom % 100; mo = 1 + $urandom % 12;
      dt = ($urandom % 3 == 0) ? mlen(mo, y) : 1 + $urandom % mlen(mo, y);
      d = 1 + $urandom % 7;
      h = $urandom % 24; mi = $urandom % 60; s = $urandom % 60;
      if ($urandom % 2 == 0) begin h = 23; mi = 59; s = 40 + $urandom % 20; end
      set_time(y, mo, dt, d, h, mi, s);
      n = 1 + $urandom % 200;
      do_tick(n);
      check_time("R3");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule